// File: doc/BRIEF.md
# Victim Line Buffer

A small fully associative store placed between a direct-mapped first-level cache and the next memory level. Whenever the first-level cache throws a line out, the line is parked here. A later first-level miss can then be served from this store instead of the slower level below. Each entry holds a block address, one line of data and a dirty flag. The block address is compared against the request in every entry at the same moment.

Each cycle the first-level cache may present a lookup (the block address it missed on) and, independently, the line it is displacing. If the lookup hits, the matching line is returned in the same cycle. The displaced line, when present, takes over the slot the hit line leaves. If there is no displaced line, the slot is freed. If the lookup misses, a read request goes to the next level, and the displaced line is written into the oldest slot in first-in-first-out order. When that slot held a dirty line, the old line is handed to the next level as a write in the same cycle. The number of entries is a parameter from 4 to 16.

All outputs are combinational from the present state and inputs. State changes take effect at the next rising clock edge. Callers must not present a displaced line whose address is already held in the buffer, nor one equal to the lookup address.

Top module: `victim_buffer`

## Requirements
- R1: After a synchronous active-low reset, every entry is empty, so the first lookup reports no hit and raises a memory read.
- R2: When `req_valid` is high, the request is compared with all valid entries in the same cycle. On a match, `hit` is 1, `hit_onehot` has bit i set, `hit_idx` equals i, and `hit_data`/`hit_dirty` give that entry's line and dirty flag. Without a hit, `hit_data` and `hit_dirty` are 0.
- R3: At most one bit of `hit_onehot` is ever set, and an empty entry never matches.
- R4: On a hit with `evict_valid` high, the displaced line (address, data, dirty) is stored in the hit slot at the next edge, and the returned line leaves the buffer.
- R5: On a hit with `evict_valid` low, the hit slot becomes empty at the next edge.
- R6: On a lookup miss, `mem_rd_valid` is 1 and `mem_rd_addr` equals `req_addr` in the same cycle. On a hit, or when no lookup is made, `mem_rd_valid` is 0.
- R7: A displaced line that does not coincide with a hit is written into the slot named by a first-in-first-out pointer. The pointer starts at slot 0 after reset and steps 0,1,…,ENTRIES-1,0 once per such insert. A swap leaves the pointer unchanged.
- R8: In an insert cycle, if the slot being overwritten holds a valid dirty line, `mem_wr_valid` is 1 with that line's address and data on `mem_wr_addr`/`mem_wr_data`. If the slot is clean or empty, `mem_wr_valid` stays 0.
- R9: With both `req_valid` and `evict_valid` low, `hit`, `mem_rd_valid` and `mem_wr_valid` are 0 and the contents do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Lookup for a first-level miss |
| req_addr | input | ADDR_W | Block address looked up |
| evict_valid | input | 1 | First-level cache is displacing a line |
| evict_addr | input | ADDR_W | Block address of the displaced line |
| evict_data | input | DATA_W | Data of the displaced line |
| evict_dirty | input | 1 | Displaced line is modified |
| hit | output | 1 | Lookup matched an entry |
| hit_onehot | output | ENTRIES | One-hot matching entry |
| hit_idx | output | IDX_W | Encoded matching entry |
| hit_data | output | DATA_W | Line returned on a hit |
| hit_dirty | output | 1 | Dirty flag of the returned line |
| mem_rd_valid | output | 1 | Read request to the next level on a miss |
| mem_rd_addr | output | ADDR_W | Block address to read |
| mem_wr_valid | output | 1 | Write-back of a dirty replaced line |
| mem_wr_addr | output | ADDR_W | Address of the written-back line |
| mem_wr_data | output | DATA_W | Data of the written-back line |

## Verification
Directed sequences first fill every slot with alternating dirty and clean lines. They then overflow the buffer, which tells a dirty write-back apart from a clean, silent replacement and shows that the pointer wraps. Swaps and plain takes on chosen slots separate a hit that refills its own slot from one that frees it; a follow-up lookup of both the old and new address confirms which line the slot now holds. Seeded random traffic mixes hits on held addresses, misses on addresses never stored, and inserts with and without a lookup. This exposes holes left by takes, which the pointer must overwrite in strict order, and idle cycles, which must leave everything unchanged.

// File: rtl/vb_pkg.sv
// Shared definitions for the victim line buffer.
// Assumes: the lookup hit is already gated by the request valid.
package vb_pkg;

    typedef enum logic [1:0] {
        VB_IDLE = 2'd0,   // nothing to do
        VB_SWAP = 2'd1,   // hit, displaced line takes the hit slot
        VB_TAKE = 2'd2,   // hit, slot is freed
        VB_FILL = 2'd3    // no hit, displaced line goes to the FIFO slot
    } vb_op_e;

    // Picks the cycle's action from lookup result and displaced-line valid.
    function automatic vb_op_e vb_decode(input logic found, input logic displaced);
        if (found)          return displaced ? VB_SWAP : VB_TAKE;
        else if (displaced) return VB_FILL;
        else                return VB_IDLE;
    endfunction

endpackage

// File: rtl/vb_match.sv
// Parallel address comparator for all entries, with a one-hot to binary encoder.
// Assumes: at most one valid entry holds any given address.
module vb_match #(
    parameter int ENTRIES = 8,
    parameter int ADDR_W  = 20,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic                             lookup_en,
    input  logic [ADDR_W-1:0]                lookup_addr,
    input  logic [ENTRIES-1:0]               ent_valid,
    input  logic [ENTRIES-1:0][ADDR_W-1:0]   ent_addr,
    output logic [ENTRIES-1:0]               match_oh,
    output logic                             match_any,
    output logic [IDX_W-1:0]                 match_idx
);

    // One comparator per entry, all evaluated together.
    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        assign match_oh[i] = lookup_en && ent_valid[i] && (ent_addr[i] == lookup_addr);
    end

    assign match_any = |match_oh;

    // Encoder: each index bit is the OR of the match lines whose index has that bit.
    for (genvar b = 0; b < IDX_W; b++) begin : g_enc
        logic [ENTRIES-1:0] sel;
        for (genvar i = 0; i < ENTRIES; i++) begin : g_sel
            if (((i >> b) & 1) == 1) begin : g_on
                assign sel[i] = match_oh[i];
            end else begin : g_off
                assign sel[i] = 1'b0;
            end
        end
        assign match_idx[b] = |sel;
    end

endmodule

// File: rtl/vb_fifo_ptr.sv
// Replacement pointer: names the oldest insert slot and steps round-robin.
// Assumes: advance is raised only in cycles that insert a line.
module vb_fifo_ptr #(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    output logic [IDX_W-1:0] ptr
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    // Steps the pointer with wrap after the last slot.
    always_ff @(posedge clk) begin
        if (!rst_n)       ptr <= '0;
        else if (advance) ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end

endmodule

// File: rtl/vb_store.sv
// Entry storage: address, line data, dirty and valid per slot.
// Assumes: write and clear never target the same slot in one cycle.
module vb_store #(
    parameter int ENTRIES = 8,
    parameter int ADDR_W  = 20,
    parameter int DATA_W  = 32,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [IDX_W-1:0]                 wr_idx,
    input  logic [ADDR_W-1:0]                wr_addr,
    input  logic [DATA_W-1:0]                wr_data,
    input  logic                             wr_dirty,
    input  logic                             clr_en,
    input  logic [IDX_W-1:0]                 clr_idx,
    output logic [ENTRIES-1:0]               ent_valid,
    output logic [ENTRIES-1:0]               ent_dirty,
    output logic [ENTRIES-1:0][ADDR_W-1:0]   ent_addr,
    output logic [ENTRIES-1:0][DATA_W-1:0]   ent_data
);

    for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
        logic              v_q;
        logic              d_q;
        logic [ADDR_W-1:0] a_q;
        logic [DATA_W-1:0] x_q;

        // Loads the slot on a write, empties it on a clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                v_q <= 1'b0;
                d_q <= 1'b0;
                a_q <= '0;
                x_q <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(i))) begin
                v_q <= 1'b1;
                d_q <= wr_dirty;
                a_q <= wr_addr;
                x_q <= wr_data;
            end else if (clr_en && (clr_idx == IDX_W'(i))) begin
                v_q <= 1'b0;
                d_q <= 1'b0;
            end
        end

        assign ent_valid[i] = v_q;
        assign ent_dirty[i] = d_q;
        assign ent_addr[i]  = a_q;
        assign ent_data[i]  = x_q;
    end

endmodule

// File: rtl/victim_buffer.sv
// Fully associative victim line buffer between a direct-mapped cache and memory.
// Hits return a line and swap in the displaced line; misses request memory and
// insert the displaced line in FIFO order, writing back a dirty replaced line.
// Assumes: ENTRIES in 4..16; a displaced line's address is never already held
// and never equals the lookup address of the same cycle.
module victim_buffer #(
    parameter int ENTRIES = 8,
    parameter int ADDR_W  = 20,
    parameter int DATA_W  = 32,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic               evict_valid,
    input  logic [ADDR_W-1:0]  evict_addr,
    input  logic [DATA_W-1:0]  evict_data,
    input  logic               evict_dirty,
    output logic               hit,
    output logic [ENTRIES-1:0] hit_onehot,
    output logic [IDX_W-1:0]   hit_idx,
    output logic [DATA_W-1:0]  hit_data,
    output logic               hit_dirty,
    output logic               mem_rd_valid,
    output logic [ADDR_W-1:0]  mem_rd_addr,
    output logic               mem_wr_valid,
    output logic [ADDR_W-1:0]  mem_wr_addr,
    output logic [DATA_W-1:0]  mem_wr_data
);
    import vb_pkg::*;

    logic [ENTRIES-1:0]             ent_valid;
    logic [ENTRIES-1:0]             ent_dirty;
    logic [ENTRIES-1:0][ADDR_W-1:0] ent_addr;
    logic [ENTRIES-1:0][DATA_W-1:0] ent_data;
    logic [ENTRIES-1:0]             match_oh;
    logic                           match_any;
    logic [IDX_W-1:0]               match_idx;
    logic [IDX_W-1:0]               fill_ptr;
    vb_op_e                         op;
    logic                           wr_en;
    logic [IDX_W-1:0]               wr_idx;
    logic                           clr_en;

    vb_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_match (
        .lookup_en   (req_valid),
        .lookup_addr (req_addr),
        .ent_valid   (ent_valid),
        .ent_addr    (ent_addr),
        .match_oh    (match_oh),
        .match_any   (match_any),
        .match_idx   (match_idx)
    );

    vb_fifo_ptr #(.ENTRIES(ENTRIES)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (op == VB_FILL),
        .ptr     (fill_ptr)
    );

    vb_store #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_addr   (evict_addr),
        .wr_data   (evict_data),
        .wr_dirty  (evict_dirty),
        .clr_en    (clr_en),
        .clr_idx   (match_idx),
        .ent_valid (ent_valid),
        .ent_dirty (ent_dirty),
        .ent_addr  (ent_addr),
        .ent_data  (ent_data)
    );

    // Chooses the cycle's action and steers the store's write port.
    always_comb begin
        op     = vb_decode(match_any, evict_valid);
        wr_en  = (op == VB_SWAP) || (op == VB_FILL);
        wr_idx = (op == VB_SWAP) ? match_idx : fill_ptr;
        clr_en = (op == VB_TAKE);
    end

    // Drives the lookup result towards the first-level cache.
    always_comb begin
        hit        = match_any;
        hit_onehot = match_oh;
        hit_idx    = match_idx;
        hit_data   = match_any ? ent_data[match_idx]  : '0;
        hit_dirty  = match_any ? ent_dirty[match_idx] : 1'b0;
    end

    // Drives the next-level read request and the dirty write-back.
    always_comb begin
        mem_rd_valid = req_valid && !match_any;
        mem_rd_addr  = req_addr;
        mem_wr_valid = (op == VB_FILL) && ent_valid[fill_ptr] && ent_dirty[fill_ptr];
        mem_wr_addr  = ent_addr[fill_ptr];
        mem_wr_data  = ent_data[fill_ptr];
    end

endmodule

// File: rtl/vb_checker.sv
// Protocol and ordering properties of the victim line buffer, bound to its top.
// Assumes: it sees the top's ports and its internal FIFO pointer.
module vb_checker #(
    parameter int ENTRIES = 8,
    parameter int ADDR_W  = 20,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic [ADDR_W-1:0]  req_addr,
    input logic               evict_valid,
    input logic               hit,
    input logic [ENTRIES-1:0] hit_onehot,
    input logic [IDX_W-1:0]   hit_idx,
    input logic               mem_rd_valid,
    input logic [ADDR_W-1:0]  mem_rd_addr,
    input logic               mem_wr_valid,
    input logic [IDX_W-1:0]   fifo_ptr
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    // R1: the cycle after reset nothing can match
    assert_empty_after_reset_R1: assert property (@(posedge clk)
        !rst_n |=> !hit);

    // R2: the encoded index points at the set one-hot bit
    assert_index_agrees_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (hit_onehot[hit_idx] && hit_onehot != '0));

    // R3: never more than one matching entry
    assert_single_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_onehot));

    // R6: a miss asks memory for the requested block
    assert_miss_reads_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !hit) |-> (mem_rd_valid && mem_rd_addr == req_addr));

    // R6: a hit never reads memory
    assert_hit_no_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> !mem_rd_valid);

    // R7: each insert steps the pointer with wrap
    assert_ptr_steps_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (evict_valid && !hit) |=>
        (fifo_ptr == (($past(fifo_ptr) == LAST) ? '0 : $past(fifo_ptr) + 1'b1)));

    // R7: swaps and idle cycles keep the pointer
    assert_ptr_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(evict_valid && !hit) |=> $stable(fifo_ptr));

    // R8: a write-back only comes from an insert
    assert_writeback_on_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_valid |-> (evict_valid && !hit));

    // R9: an idle cycle raises nothing
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid && !evict_valid) |-> (!hit && !mem_rd_valid && !mem_wr_valid));

endmodule

bind victim_buffer vb_checker #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_vb_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_addr     (req_addr),
    .evict_valid  (evict_valid),
    .hit          (hit),
    .hit_onehot   (hit_onehot),
    .hit_idx      (hit_idx),
    .mem_rd_valid (mem_rd_valid),
    .mem_rd_addr  (mem_rd_addr),
    .mem_wr_valid (mem_wr_valid),
    .fifo_ptr     (fill_ptr)
);

// File: tb/test_victim_buffer.sv
// Self-checking bench: directed corner cases, then seeded random traffic,
// compared against a behavioural model of the buffer kept in the bench.
module test_victim_buffer;

    localparam int CLK_PERIOD = 10;
    localparam int ENTRIES    = 8;
    localparam int ADDR_W     = 20;
    localparam int DATA_W     = 32;
    localparam int IDX_W      = $clog2(ENTRIES);

    logic               clk = 1'b0;
    logic               rst_n;
    logic               req_valid, evict_valid, evict_dirty;
    logic [ADDR_W-1:0]  req_addr, evict_addr;
    logic [DATA_W-1:0]  evict_data;
    logic               hit, hit_dirty, mem_rd_valid, mem_wr_valid;
    logic [ENTRIES-1:0] hit_onehot;
    logic [IDX_W-1:0]   hit_idx;
    logic [DATA_W-1:0]  hit_data, mem_wr_data;
    logic [ADDR_W-1:0]  mem_rd_addr, mem_wr_addr;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // Bench model of the buffer contents
    bit              m_valid [ENTRIES];
    bit              m_dirty [ENTRIES];
    bit [ADDR_W-1:0] m_addr  [ENTRIES];
    bit [DATA_W-1:0] m_data  [ENTRIES];
    int              m_ptr;
    int unsigned     fresh = 32'h100;

    victim_buffer #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_victim_buffer (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_addr(req_addr),
        .evict_valid(evict_valid), .evict_addr(evict_addr),
        .evict_data(evict_data), .evict_dirty(evict_dirty),
        .hit(hit), .hit_onehot(hit_onehot), .hit_idx(hit_idx),
        .hit_data(hit_data), .hit_dirty(hit_dirty),
        .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
        .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr),
        .mem_wr_data(mem_wr_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic int find(input bit [ADDR_W-1:0] a);
        for (int i = 0; i < ENTRIES; i++)
            if (m_valid[i] && m_addr[i] == a) return i;
        return -1;
    endfunction

    function automatic bit [ADDR_W-1:0] new_addr();
        fresh++;
        return ADDR_W'(fresh);
    endfunction

    // One operation: drive after the falling edge, check, then update the model.
    task automatic run_op(input string tag, input bit rv, input bit [ADDR_W-1:0] ra,
                          input bit ev, input bit [ADDR_W-1:0] ea,
                          input bit [DATA_W-1:0] ed, input bit edty);
        int f;
        bit eh, ewr;
        @(negedge clk);
        req_valid = rv; req_addr = ra;
        evict_valid = ev; evict_addr = ea; evict_data = ed; evict_dirty = edty;
        #2;
        f   = rv ? find(ra) : -1;
        eh  = (f >= 0);
        ewr = ev && !eh && m_valid[m_ptr] && m_dirty[m_ptr];
        chk(tag, "hit", hit, eh);
        chk(tag, "hit_onehot", hit_onehot, eh ? (64'd1 << f) : 64'd0);
        if (eh) chk(tag, "hit_idx", hit_idx, f);
        chk(tag, "hit_data", hit_data, eh ? m_data[f] : 0);
        chk(tag, "hit_dirty", hit_dirty, eh ? m_dirty[f] : 0);
        chk(tag, "mem_rd_valid", mem_rd_valid, rv && !eh);
        if (rv && !eh) chk(tag, "mem_rd_addr", mem_rd_addr, ra);
        chk(tag, "mem_wr_valid", mem_wr_valid, ewr);
        if (ewr) begin
            chk(tag, "mem_wr_addr", mem_wr_addr, m_addr[m_ptr]);
            chk(tag, "mem_wr_data", mem_wr_data, m_data[m_ptr]);
        end
        if (eh && ev) begin
            m_addr[f] = ea; m_data[f] = ed; m_dirty[f] = edty; m_valid[f] = 1;
        end else if (eh) begin
            m_valid[f] = 0; m_dirty[f] = 0;
        end else if (ev) begin
            m_addr[m_ptr] = ea; m_data[m_ptr] = ed; m_dirty[m_ptr] = edty; m_valid[m_ptr] = 1;
            m_ptr = (m_ptr + 1) % ENTRIES;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        bit [ADDR_W-1:0] a0, x, held3;
        void'($urandom(32'h5eed));
        rst_n = 0; req_valid = 0; evict_valid = 0;
        req_addr = '0; evict_addr = '0; evict_data = '0; evict_dirty = 0;
        for (int i = 0; i < ENTRIES; i++) begin
            m_valid[i] = 0; m_dirty[i] = 0; m_addr[i] = '0; m_data[i] = '0;
        end
        m_ptr = 0;
        repeat (3) @(posedge clk);
        rst_n = 1;

        // R1: empty after reset, lookup misses and reads memory
        run_op("R1", 1, 20'h00123, 0, '0, '0, 0);

        // R7 R8: fill all slots, alternating dirty lines; no write-back into empty slots
        a0 = ADDR_W'(fresh + 1);
        for (int i = 0; i < ENTRIES; i++)
            run_op("R7", 0, '0, 1, new_addr(), DATA_W'(32'hA000 + i), (i % 2) == 0);

        // R2: hits on each slot, swapping in a fresh line each time
        for (int i = 0; i < ENTRIES; i++)
            run_op("R2", 1, a0 + ADDR_W'(i), 1, new_addr(), DATA_W'(32'hB000 + i), (i % 2) == 1);

        // R8: overflow wraps to slot 0 (clean now) and slot 1 (dirty now)
        run_op("R8", 1, 20'h80001, 1, new_addr(), 32'hC0, 0);
        run_op("R8", 1, 20'h80002, 1, new_addr(), 32'hC1, 1);

        // R4: swap on slot 3; new line then hits at slot 3, old one misses
        held3 = m_addr[3];
        x = new_addr();
        run_op("R4", 1, held3, 1, x, 32'hD3, 1);
        run_op("R4", 1, held3, 0, '0, '0, 0);
        run_op("R4", 1, x, 1, new_addr(), 32'hD4, 0);

        // R5: take slot 5 without a displaced line, then it misses
        x = m_addr[5];
        run_op("R5", 1, x, 0, '0, '0, 0);
        run_op("R5", 1, x, 0, '0, '0, 0);

        // R9: idle cycles, then a held line still hits
        run_op("R9", 0, '0, 0, '0, '0, 0);
        run_op("R9", 0, '0, 0, '0, '0, 0);
        run_op("R9", 1, m_addr[6], 1, new_addr(), 32'hE6, 1);

        // R3 R6 R7 R8: seeded random mix
        for (int n = 0; n < 600; n++) begin
            bit rv, ev;
            bit [ADDR_W-1:0] ra;
            int pick;
            rv = ($urandom % 4) != 0;
            ev = ($urandom % 3) != 0;
            pick = $urandom % ENTRIES;
            if (($urandom % 2) == 0 && m_valid[pick]) ra = m_addr[pick];
            else ra = {1'b1, ADDR_W'($urandom) >> 1};
            run_op("R3/R6", rv, ra, ev, new_addr(), DATA_W'($urandom), $urandom % 2);
        end

        @(negedge clk);
        req_valid = 0; evict_valid = 0;
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule